// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the architectural state update that a small RISC core makes when it takes a synchronous exception or accepts an interrupt. The pipeline gives it the program counter of the instruction being abandoned, the live status word, and a flag that says whether that instruction sits in a branch delay slot. It also gives it a take-exception strobe with a cause code, and two interrupt request lines: one from an external interrupt controller and one from the tick timer.

On the clock edge where an event is taken, the block registers the saved exception PC, with corrections for delay slots and system calls. It also registers a copy of the old status word, the rewritten status word for supervisor entry, and the vector address for the fetch unit. For that one cycle it pulses an entry strobe, a delay-slot-clear strobe and a TLB-flush strobe. When the block is handed a cause code it cannot vector, it pulses an error output and leaves every saved value untouched.

Cause codes are `CAUSE_W` bits wide (default 4). Codes 1 to `NUM_CAUSES-1` (default 13) are defined. The tick interrupt uses cause 5, the external interrupt cause 8, and the system call cause 12.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On a taken event that is neither in a delay slot nor a system call, `epc_o` equals the `pc_i` presented in the cycle before.
- R2: When `dslot_i` is 1 on a taken event, `epc_o` is `pc_i - 4`, status bit 13 (delay-slot indicator) is set in `sr_o`, and `dslot_clr_o` pulses for one cycle.
- R3: When the taken cause is 12 (system call), 4 is added to the saved PC, and this combines with R2, so a system call in a delay slot saves `pc_i` itself.
- R4: On a taken event, `esr_o` equals `sr_i` as it was presented, before any entry modification.
- R5: On a taken event, `sr_o` is `sr_i` with bit 0 (supervisor) set, and with bits 1 (tick enable), 2 (interrupt enable), 5 (data MMU enable) and 6 (instruction MMU enable) cleared. All other bits are kept, apart from the R2 rule for bit 13.
- R6: On a taken event, `vec_pc_o` equals the taken cause shifted left by 8, and `cause_o` shows that cause.
- R7: With no strobe, the external request is taken as cause 8 only when `sr_i` bit 2 is 1, and the tick request is taken as cause 5 only when `sr_i` bit 1 is 1. A masked request produces no entry.
- R8: When both requests are pending and both are enabled, cause 5 (tick) is taken.
- R9: `tlb_flush_o` pulses for one cycle together with `entry_o` on every taken event.
- R10: A strobe carrying cause 0, or a cause of 14 or above, pulses `unhandled_o` and raises neither `entry_o` nor `tlb_flush_o`. `epc_o`, `esr_o`, `sr_o`, `vec_pc_o` and `cause_o` keep their values.
- R11: A take-exception strobe wins over any pending, enabled interrupt in the same cycle. This holds even when its cause is unhandled, in which case nothing is taken.
- R12: An active-low synchronous reset clears every output to zero. Entry, error, flush and delay-slot-clear strobes last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| take_exc_i | input | 1 | Synchronous exception strobe |
| exc_cause_i | input | CAUSE_W | Cause code carried with the strobe |
| pc_i | input | AW | PC of the interrupted instruction |
| sr_i | input | SW | Current status word |
| dslot_i | input | 1 | Instruction sits in a delay slot |
| irq_ext_i | input | 1 | External interrupt request |
| irq_tick_i | input | 1 | Tick timer interrupt request |
| entry_o | output | 1 | One-cycle pulse: event taken |
| cause_o | output | CAUSE_W | Cause of the last taken event |
| vec_pc_o | output | AW | Vector address for the fetch unit |
| epc_o | output | AW | Saved exception PC |
| esr_o | output | SW | Saved status word |
| sr_o | output | SW | Rewritten status word |
| dslot_clr_o | output | 1 | One-cycle pulse: clear the delay-slot flag |
| tlb_flush_o | output | 1 | One-cycle pulse: flush the TLB |
| unhandled_o | output | 1 | One-cycle pulse: strobe with an unvectorable cause |

## Verification
The hardest cases to reach are the ones where several inputs collide in one cycle. One is a system call raised from a delay slot while both interrupt lines are pending and enabled: the two PC corrections must cancel, and the strobe must still win. Another is an unhandled cause arriving while an enabled interrupt is pending, where nothing may be taken at all. The stimulus table places these collisions in dedicated rows. Before each row, the bench leaves the saved registers with values that differ from the row's inputs, so an illegal update or a lost correction shows up in the very next sample.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;
  // status word bit positions (decoded by the rest of the core)
  localparam int SR_SUP  = 0;
  localparam int SR_TICK = 1;
  localparam int SR_IRQ  = 2;
  localparam int SR_DMMU = 5;
  localparam int SR_IMMU = 6;
  localparam int SR_DSX  = 13;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_SYNC = 2'd1,
    SRC_TICK = 2'd2,
    SRC_EXT  = 2'd3
  } src_e;
endpackage

// File: rtl/exc_cause_arb.sv
`timescale 1ns/1ps
module exc_cause_arb
  import exc_entry_pkg::*;
#(
  parameter int CAUSE_W    = 4,
  parameter int NUM_CAUSES = 14,
  parameter int TICK_CAUSE = 5,
  parameter int EXT_CAUSE  = 8
) (
  input  logic               take_exc_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic               irq_ext_i,
  input  logic               irq_tick_i,
  input  logic               ext_en_i,
  input  logic               tick_en_i,
  output src_e               src_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               take_o,
  output logic               bad_o
);
  localparam logic [CAUSE_W-1:0] TickCode = CAUSE_W'(TICK_CAUSE);
  localparam logic [CAUSE_W-1:0] ExtCode  = CAUSE_W'(EXT_CAUSE);

  function automatic logic cause_ok(input logic [CAUSE_W-1:0] c);
    return (c != '0) && (32'(c) < NUM_CAUSES);
  endfunction

  logic tick_live, ext_live;
  assign tick_live = irq_tick_i && tick_en_i;
  assign ext_live  = irq_ext_i && ext_en_i;

  always_comb begin
    src_o   = SRC_NONE;
    cause_o = '0;
    if (take_exc_i) begin
      src_o   = SRC_SYNC;
      cause_o = exc_cause_i;
    end else if (tick_live) begin
      src_o   = SRC_TICK;
      cause_o = TickCode;
    end else if (ext_live) begin
      src_o   = SRC_EXT;
      cause_o = ExtCode;
    end
  end

  assign bad_o  = (src_o == SRC_SYNC) && !cause_ok(cause_o);
  assign take_o = (src_o != SRC_NONE) && !bad_o;
endmodule

// File: rtl/exc_pc_calc.sv
`timescale 1ns/1ps
module exc_pc_calc #(
  parameter int AW            = 32,
  parameter int CAUSE_W       = 4,
  parameter int VEC_SHIFT     = 8,
  parameter int SYSCALL_CAUSE = 12
) (
  input  logic [AW-1:0]      pc_i,
  input  logic               dslot_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [AW-1:0]      epc_o,
  output logic [AW-1:0]      vec_o
);
  localparam logic [AW-1:0] Step = AW'(4);
  localparam logic [CAUSE_W-1:0] SysCode = CAUSE_W'(SYSCALL_CAUSE);

  function automatic logic [AW-1:0] saved_pc(input logic [AW-1:0] pc,
                                            input logic ds,
                                            input logic sys);
    logic [AW-1:0] v;
    v = pc;
    if (ds)  v = v - Step;
    if (sys) v = v + Step;
    return v;
  endfunction

  function automatic logic [AW-1:0] slot_addr(input logic [CAUSE_W-1:0] c);
    return {{(AW-CAUSE_W){1'b0}}, c} << VEC_SHIFT;
  endfunction

  assign epc_o = saved_pc(pc_i, dslot_i, cause_i == SysCode);
  assign vec_o = slot_addr(cause_i);
endmodule

// File: rtl/exc_sr_rewrite.sv
`timescale 1ns/1ps
module exc_sr_rewrite
  import exc_entry_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic [SW-1:0] sr_i,
  input  logic          dslot_i,
  output logic [SW-1:0] sr_o
);
  localparam logic [SW-1:0] ClrMask = (SW'(1) << SR_TICK) | (SW'(1) << SR_IRQ) |
                                      (SW'(1) << SR_DMMU) | (SW'(1) << SR_IMMU);
  localparam logic [SW-1:0] SupBit  = SW'(1) << SR_SUP;
  localparam logic [SW-1:0] DsxBit  = SW'(1) << SR_DSX;

  function automatic logic [SW-1:0] enter_sr(input logic [SW-1:0] s, input logic ds);
    logic [SW-1:0] v;
    v = (s & ~ClrMask) | SupBit;
    if (ds) v = v | DsxBit;
    return v;
  endfunction

  assign sr_o = enter_sr(sr_i, dslot_i);
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int AW            = 32,
  parameter int SW            = 16,
  parameter int CAUSE_W       = 4,
  parameter int NUM_CAUSES    = 14,
  parameter int TICK_CAUSE    = 5,
  parameter int EXT_CAUSE     = 8,
  parameter int SYSCALL_CAUSE = 12,
  parameter int VEC_SHIFT     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_exc_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic [AW-1:0]      pc_i,
  input  logic [SW-1:0]      sr_i,
  input  logic               dslot_i,
  input  logic               irq_ext_i,
  input  logic               irq_tick_i,
  output logic               entry_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [AW-1:0]      vec_pc_o,
  output logic [AW-1:0]      epc_o,
  output logic [SW-1:0]      esr_o,
  output logic [SW-1:0]      sr_o,
  output logic               dslot_clr_o,
  output logic               tlb_flush_o,
  output logic               unhandled_o
);
  // named internal events
  src_e               sel_src;
  logic [CAUSE_W-1:0] sel_cause;
  logic               ev_take;
  logic               ev_bad;
  logic [AW-1:0]      nxt_epc;
  logic [AW-1:0]      nxt_vec;
  logic [SW-1:0]      nxt_sr;

  exc_cause_arb #(
    .CAUSE_W(CAUSE_W), .NUM_CAUSES(NUM_CAUSES),
    .TICK_CAUSE(TICK_CAUSE), .EXT_CAUSE(EXT_CAUSE)
  ) u_arb (
    .take_exc_i (take_exc_i),
    .exc_cause_i(exc_cause_i),
    .irq_ext_i  (irq_ext_i),
    .irq_tick_i (irq_tick_i),
    .ext_en_i   (sr_i[SR_IRQ]),
    .tick_en_i  (sr_i[SR_TICK]),
    .src_o      (sel_src),
    .cause_o    (sel_cause),
    .take_o     (ev_take),
    .bad_o      (ev_bad)
  );

  exc_pc_calc #(
    .AW(AW), .CAUSE_W(CAUSE_W), .VEC_SHIFT(VEC_SHIFT), .SYSCALL_CAUSE(SYSCALL_CAUSE)
  ) u_pc (
    .pc_i   (pc_i),
    .dslot_i(dslot_i),
    .cause_i(sel_cause),
    .epc_o  (nxt_epc),
    .vec_o  (nxt_vec)
  );

  exc_sr_rewrite #(.SW(SW)) u_sr (
    .sr_i   (sr_i),
    .dslot_i(dslot_i),
    .sr_o   (nxt_sr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_o     <= 1'b0;
      cause_o     <= '0;
      vec_pc_o    <= '0;
      epc_o       <= '0;
      esr_o       <= '0;
      sr_o        <= '0;
      dslot_clr_o <= 1'b0;
      tlb_flush_o <= 1'b0;
      unhandled_o <= 1'b0;
    end else begin
      entry_o     <= ev_take;
      tlb_flush_o <= ev_take;
      dslot_clr_o <= ev_take && dslot_i;
      unhandled_o <= ev_bad;
      if (ev_take) begin
        cause_o  <= sel_cause;
        vec_pc_o <= nxt_vec;
        epc_o    <= nxt_epc;
        esr_o    <= sr_i;
        sr_o     <= nxt_sr;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
`timescale 1ns/1ps
module exc_entry_ctrl_chk
  import exc_entry_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SW         = 16,
  parameter int CAUSE_W    = 4,
  parameter int TICK_CAUSE = 5,
  parameter int VEC_SHIFT  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               take_exc_i,
  input logic [CAUSE_W-1:0] exc_cause_i,
  input logic [SW-1:0]      sr_i,
  input logic               dslot_i,
  input logic               irq_ext_i,
  input logic               irq_tick_i,
  input logic               entry_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic [AW-1:0]      vec_pc_o,
  input logic [AW-1:0]      epc_o,
  input logic [SW-1:0]      esr_o,
  input logic [SW-1:0]      sr_o,
  input logic               dslot_clr_o,
  input logic               tlb_flush_o,
  input logic               unhandled_o
);
  localparam logic [CAUSE_W-1:0] TickCode = CAUSE_W'(TICK_CAUSE);

  AST_DSLOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> (dslot_clr_o == $past(dslot_i)) && (!dslot_clr_o || sr_o[SR_DSX])); // R2
  AST_ESR_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> esr_o == $past(sr_i)); // R4
  AST_SR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> sr_o[SR_SUP] && !sr_o[SR_IRQ] && !sr_o[SR_TICK] && !sr_o[SR_DMMU] && !sr_o[SR_IMMU]); // R5
  AST_VEC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> vec_pc_o[VEC_SHIFT-1:0] == '0); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_exc_i && !(irq_tick_i && sr_i[SR_TICK]) && !(irq_ext_i && sr_i[SR_IRQ])) |=> !entry_o); // R7
  AST_TICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_exc_i && irq_tick_i && sr_i[SR_TICK]) |=> entry_o && cause_o == TickCode); // R8
  AST_FLUSH_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> tlb_flush_o); // R9
  AST_UNHANDLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    unhandled_o |-> !entry_o && !tlb_flush_o && $stable(epc_o) && $stable(sr_o) && $stable(esr_o)); // R10
  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc_i |=> (entry_o && cause_o == $past(exc_cause_i)) || (unhandled_o && !entry_o)); // R11
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(
  .AW(AW), .SW(SW), .CAUSE_W(CAUSE_W), .TICK_CAUSE(TICK_CAUSE), .VEC_SHIFT(VEC_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .take_exc_i(take_exc_i), .exc_cause_i(exc_cause_i),
  .sr_i(sr_i), .dslot_i(dslot_i), .irq_ext_i(irq_ext_i), .irq_tick_i(irq_tick_i),
  .entry_o(entry_o), .cause_o(cause_o), .vec_pc_o(vec_pc_o), .epc_o(epc_o),
  .esr_o(esr_o), .sr_o(sr_o), .dslot_clr_o(dslot_clr_o), .tlb_flush_o(tlb_flush_o),
  .unhandled_o(unhandled_o)
);

// File: tb/exc_entry_ctrl_bench.sv
`timescale 1ns/1ps
module exc_entry_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take_exc_i = 1'b0;
  logic [3:0]  exc_cause_i = '0;
  logic [31:0] pc_i = '0;
  logic [15:0] sr_i = '0;
  logic        dslot_i = 1'b0;
  logic        irq_ext_i = 1'b0;
  logic        irq_tick_i = 1'b0;
  logic        entry_o, dslot_clr_o, tlb_flush_o, unhandled_o;
  logic [3:0]  cause_o;
  logic [31:0] vec_pc_o, epc_o;
  logic [15:0] esr_o, sr_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .take_exc_i(take_exc_i), .exc_cause_i(exc_cause_i),
    .pc_i(pc_i), .sr_i(sr_i), .dslot_i(dslot_i), .irq_ext_i(irq_ext_i),
    .irq_tick_i(irq_tick_i), .entry_o(entry_o), .cause_o(cause_o), .vec_pc_o(vec_pc_o),
    .epc_o(epc_o), .esr_o(esr_o), .sr_o(sr_o), .dslot_clr_o(dslot_clr_o),
    .tlb_flush_o(tlb_flush_o), .unhandled_o(unhandled_o)
  );

  typedef struct packed {
    logic        take;
    logic [3:0]  cause;
    logic        ext;
    logic        tick;
    logic [31:0] pc;
    logic [15:0] sr;
    logic        ds;
    logic        x_entry;
    logic        x_err;
    logic [3:0]  x_cause;
  } row_t;

  localparam int NROWS = 14;
  localparam row_t TBL [NROWS] = '{
    // take cause ext tick pc           sr        ds  entry err xcause
    '{1'b1, 4'd3,  1'b0, 1'b0, 32'h0000_1000, 16'h0066, 1'b0, 1'b1, 1'b0, 4'd3},  // R1 R5
    '{1'b1, 4'd12, 1'b0, 1'b0, 32'h0000_2000, 16'h0006, 1'b0, 1'b1, 1'b0, 4'd12}, // R3
    '{1'b1, 4'd7,  1'b0, 1'b0, 32'h0000_4000, 16'h1040, 1'b1, 1'b1, 1'b0, 4'd7},  // R2
    '{1'b1, 4'd12, 1'b1, 1'b1, 32'h0000_3000, 16'h0006, 1'b1, 1'b1, 1'b0, 4'd12}, // R2 R3 R11
    '{1'b0, 4'd0,  1'b1, 1'b1, 32'h0000_5000, 16'h0006, 1'b0, 1'b1, 1'b0, 4'd5},  // R8
    '{1'b0, 4'd0,  1'b1, 1'b1, 32'h0000_6000, 16'h0004, 1'b0, 1'b1, 1'b0, 4'd8},  // R7
    '{1'b0, 4'd0,  1'b1, 1'b1, 32'h0000_7000, 16'h0002, 1'b0, 1'b1, 1'b0, 4'd5},  // R7
    '{1'b0, 4'd0,  1'b1, 1'b0, 32'h0000_8000, 16'h0002, 1'b0, 1'b0, 1'b0, 4'd0},  // R7 masked ext
    '{1'b0, 4'd0,  1'b0, 1'b1, 32'h0000_8800, 16'h0004, 1'b0, 1'b0, 1'b0, 4'd0},  // R7 masked tick
    '{1'b1, 4'd2,  1'b1, 1'b1, 32'h0000_9000, 16'h0006, 1'b0, 1'b1, 1'b0, 4'd2},  // R11
    '{1'b1, 4'd0,  1'b1, 1'b1, 32'h0000_A000, 16'h0006, 1'b1, 1'b0, 1'b1, 4'd0},  // R10 R11
    '{1'b1, 4'd14, 1'b0, 1'b0, 32'h0000_B000, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd0},  // R10
    '{1'b1, 4'd13, 1'b0, 1'b0, 32'h0000_C000, 16'hFFFF, 1'b0, 1'b1, 1'b0, 4'd13}, // R6 top cause
    '{1'b1, 4'd15, 1'b0, 1'b1, 32'h0000_D000, 16'h0002, 1'b0, 1'b0, 1'b1, 4'd0}   // R10 R11
  };

  // bench model of the saved state
  logic [3:0]  m_cause = '0;
  logic [31:0] m_vec = '0, m_epc = '0;
  logic [15:0] m_esr = '0, m_sr = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string ctx);
    check({ctx, " R6 cause_o"}, 32'(cause_o), 32'(m_cause));
    check({ctx, " R6 vec_pc_o"}, vec_pc_o, m_vec);
    check({ctx, " R1 R2 R3 epc_o"}, epc_o, m_epc);
    check({ctx, " R4 esr_o"}, 32'(esr_o), 32'(m_esr));
    check({ctx, " R5 sr_o"}, 32'(sr_o), 32'(m_sr));
  endtask

  task automatic drive_idle();
    take_exc_i = 1'b0; exc_cause_i = '0; irq_ext_i = 1'b0; irq_tick_i = 1'b0;
    dslot_i = 1'b0; pc_i = 32'hFFFF_0000; sr_i = 16'h0000;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    drive_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset entry_o", 32'(entry_o), 0);
    check("R12 reset strobes", 32'({dslot_clr_o, tlb_flush_o, unhandled_o}), 0);
    check_regs("R12 reset");
    rst_n = 1'b1;

    for (int i = 0; i < NROWS; i++) begin
      row_t r;
      logic [31:0] e;
      r = TBL[i];
      @(negedge clk);
      take_exc_i = r.take; exc_cause_i = r.cause; irq_ext_i = r.ext;
      irq_tick_i = r.tick; pc_i = r.pc; sr_i = r.sr; dslot_i = r.ds;
      if (r.x_entry) begin
        e = r.pc;
        if (r.ds) e = e - 32'd4;
        if (r.x_cause == 4'd12) e = e + 32'd4;
        m_epc = e;
        m_cause = r.x_cause;
        m_vec = 32'(r.x_cause) * 32'd256;
        m_esr = r.sr;
        m_sr = (r.sr & ~16'h0066) | 16'h0001 | (r.ds ? 16'h2000 : 16'h0000);
      end
      @(negedge clk);
      check($sformatf("row%0d R7 R8 R11 entry_o", i), 32'(entry_o), 32'(r.x_entry));
      check($sformatf("row%0d R9 tlb_flush_o", i), 32'(tlb_flush_o), 32'(r.x_entry));
      check($sformatf("row%0d R10 unhandled_o", i), 32'(unhandled_o), 32'(r.x_err));
      check($sformatf("row%0d R2 dslot_clr_o", i), 32'(dslot_clr_o), 32'(r.x_entry & r.ds));
      check_regs($sformatf("row%0d", i));
      drive_idle();
    end

    // R12 strobes last one cycle: idle cycle after an entry
    @(negedge clk);
    take_exc_i = 1'b1; exc_cause_i = 4'd9; pc_i = 32'h0000_0100; sr_i = 16'h0020;
    m_cause = 4'd9; m_vec = 32'h0000_0900; m_epc = 32'h0000_0100;
    m_esr = 16'h0020; m_sr = 16'h0001;
    @(negedge clk);
    drive_idle();
    check("R9 flush on entry", 32'(tlb_flush_o), 1);
    @(negedge clk);
    check("R12 entry_o one cycle", 32'(entry_o), 0);
    check("R12 tlb_flush_o one cycle", 32'(tlb_flush_o), 0);
    check_regs("R12 hold after idle");

    // R12 reset wins over a strobe in the same cycle
    take_exc_i = 1'b1; exc_cause_i = 4'd4; pc_i = 32'h0000_0200; rst_n = 1'b0;
    @(negedge clk);
    m_cause = '0; m_vec = '0; m_epc = '0; m_esr = '0; m_sr = '0;
    check("R12 reset entry_o", 32'(entry_o), 0);
    check_regs("R12 reset mid run");
    drive_idle();
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule